// File: doc/BRIEF.md
# External Interrupt Sense and Pending Unit

This unit conditions eight active-low external interrupt pins for a downstream prioritizer. Each pin is brought into the clock domain through a synchronizer. A per-line sense bit then treats it either as a level request or as a falling-edge event. Edge events are held in a pending bit until software acknowledges them by writing a one to that bit. Level requests simply track the pin. A per-line enable gates each pending bit onto a registered request vector.

Software reaches three registers through a plain write/read port: sense control, pending and enable. Line 0 can be steered away from the normal request vector onto a separate machine-check output by a routing bit held in the enable register. Encodings other than the two sense modes cannot be represented. Bits outside the defined fields are dropped on write and read back as zero.

Top module: `ext_irq_sense`

## Requirements
- R1: After synchronous reset every line is in level mode, the enable, routing and pending bits are 0, and `req_o`, `mchk_o` and `rdata_o` are 0.
- R2: Address 0 selects sense control, address 1 selects pending and address 2 selects enable. A read pulse on `rd_en_i` loads `rdata_o` at the next rising edge. Address 3 reads as zero.
- R3: The edge-select bit of line n is bit 15-n of sense control, so line 0 uses bit 15 and line 7 uses bit 8. All other bits of that register ignore writes and read as 0, so only the two modes exist.
- R4: In level mode (edge-select 0) the pending bit of line n, which is bit 31-n, is 1 exactly while the synchronized pin is low. Writing one to it has no effect.
- R5: `req_o[n]` is 1 only when pending bit n and enable bit 31-n are both 1. It follows a pin change within five clock cycles.
- R6: In edge mode (edge-select 1), a high-to-low transition of the synchronized pin sets the pending bit. The bit stays set after the pin returns high, and it never sets without such a transition.
- R7: In edge mode, writing 1 to pending bit 31-n clears it, and writing 0 leaves it unchanged.
- R8: When a falling edge and a clearing write reach the same line in the same cycle, the pending bit ends up set.
- R9: While routing bit 0 of the enable register is 1, enabled pending line 0 drives `mchk_o` and `req_o[0]` stays 0. While the routing bit is 0, `mchk_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 8 | Asynchronous active-low interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| req_o | output | 8 | Enabled pending requests to the prioritizer |
| mchk_o | output | 1 | Machine-check request from line 0 when routed |

## Verification
Several rules are checked by properties on every cycle. Requests never appear for disabled lines. Level lines mirror the synchronized pin. An edge bit never rises without a falling edge and never drops without a clearing write. A coincident event always beats a clear. The routed line never shows on both outputs at once. The bench scenarios are the only evidence for other behaviour: the register bit positions, the reserved-bit readback, the end-to-end latency from pin to request, and the exact collision cycle. For the collision, the clearing write is placed on the cycle in which the edge detector fires.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SEL_SENSE = 2'd0,
    SEL_PEND  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/eis_line.sv
module eis_line (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  input  logic edge_sel_i,
  input  logic clr_i,
  output logic pend_o,
  output logic fall_o
);
  logic prev_q;

  // previous synchronized sample; idle level is high
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_n_i;
  end

  assign fall_o = prev_q & ~pin_n_i;

  // edge: an event outranks a clear; level: mirror the pin
  always_ff @(posedge clk) begin
    if (rst)             pend_o <= 1'b0;
    else if (edge_sel_i) pend_o <= fall_o | (pend_o & ~clr_i);
    else                 pend_o <= ~pin_n_i;
  end
endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import eis_pkg::*;
#(
  parameter int N = 8,
  parameter int DW = 32,
  parameter int AW = 2,
  parameter int SENSE_TOP = 15,
  parameter int ROUTE_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  edge_sel_o,
  output logic [N-1:0]  en_o,
  output logic          route_o,
  output logic [N-1:0]  clr_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i[1:0]);

  logic wr_sense, wr_pend, wr_mask;
  assign wr_sense = wr_en_i && (sel == SEL_SENSE);
  assign wr_pend  = wr_en_i && (sel == SEL_PEND);
  assign wr_mask  = wr_en_i && (sel == SEL_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_sel_o <= '0;
      en_o       <= '0;
      route_o    <= 1'b0;
    end else begin
      if (wr_sense)
        for (int n = 0; n < N; n++) edge_sel_o[n] <= wdata_i[SENSE_TOP-n];
      if (wr_mask) begin
        for (int n = 0; n < N; n++) en_o[n] <= wdata_i[DW-1-n];
        route_o <= wdata_i[ROUTE_BIT];
      end
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_clr
      assign clr_o[g] = wr_pend & wdata_i[DW-1-g];
    end
  endgenerate
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int N = 8,
  parameter int DW = 32,
  parameter int AW = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SENSE_TOP = 15,
  parameter int ROUTE_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_n_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [N-1:0]  req_o,
  output logic          mchk_o
);
  localparam logic [N-1:0] LINE0 = N'(1);

  logic [N-1:0] sync_n, edge_sel, en, clr, pend, fall;
  logic         route;

  eis_sync #(.W(N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(irq_n_i), .q_o(sync_n)
  );

  eis_regs #(.N(N), .DW(DW), .AW(AW), .SENSE_TOP(SENSE_TOP), .ROUTE_BIT(ROUTE_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .edge_sel_o(edge_sel), .en_o(en), .route_o(route), .clr_o(clr)
  );

  generate
    for (genvar g = 0; g < N; g++) begin : g_line
      eis_line u_line (
        .clk(clk), .rst(rst), .pin_n_i(sync_n[g]), .edge_sel_i(edge_sel[g]),
        .clr_i(clr[g]), .pend_o(pend[g]), .fall_o(fall[g])
      );
    end
  endgenerate

  logic [DW-1:0] img_sense, img_pend, img_mask, rd_mux;
  always_comb begin
    img_sense = '0;
    img_pend  = '0;
    img_mask  = '0;
    for (int n = 0; n < N; n++) begin
      img_sense[SENSE_TOP-n] = edge_sel[n];
      img_pend[DW-1-n]       = pend[n];
      img_mask[DW-1-n]       = en[n];
    end
    img_mask[ROUTE_BIT] = route;
    case (reg_sel_e'(addr_i[1:0]))
      SEL_SENSE: rd_mux = img_sense;
      SEL_PEND:  rd_mux = img_pend;
      SEL_MASK:  rd_mux = img_mask;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      req_o   <= '0;
      mchk_o  <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_mux;
      req_o  <= pend & en & ~(route ? LINE0 : '0);
      mchk_o <= route & pend[0] & en[0];
    end
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] sync_n,
  input logic [N-1:0] edge_sel,
  input logic [N-1:0] en,
  input logic [N-1:0] clr,
  input logic [N-1:0] pend,
  input logic [N-1:0] fall,
  input logic [N-1:0] req_o,
  input logic         mchk_o
);
  // R4: level lines mirror the inverted synchronized pin one cycle later
  p_level_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pend ^ ~$past(sync_n)) & ~$past(edge_sel)) == '0));

  // R5: no request on a line whose enable was clear
  p_req_gated_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_o & ~$past(en)) == '0));

  // R6: an edge line only rises after a detected falling edge
  p_edge_cause_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & $past(edge_sel) & ~$past(fall)) == '0));

  // R7: an edge pending bit without a clearing write is kept
  p_w0_keep_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend & edge_sel & ~clr) & ~pend) == '0));

  // R8: a coincident event beats a clear
  p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
    |(fall & edge_sel & clr) |=> (($past(fall & edge_sel & clr) & ~pend) == '0));

  // R9: routed line 0 never appears on both outputs
  p_route_excl_r9: assert property (@(posedge clk) disable iff (rst)
    mchk_o |-> !req_o[0]);
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .sync_n(sync_n), .edge_sel(edge_sel), .en(en),
  .clr(clr), .pend(pend), .fall(fall), .req_o(req_o), .mchk_o(mchk_o)
);

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/1ps
module ext_irq_sense_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_n = 8'hFF;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  req;
  logic        mchk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense dut_i (
    .clk(clk), .rst(rst), .irq_n_i(irq_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .req_o(req), .mchk_o(mchk)
  );

  // level-mode table: enable byte, pin state, expected request byte
  localparam int NV = 6;
  localparam logic [7:0] T_EN  [NV] = '{8'hFF, 8'hFF, 8'h0F, 8'hF0, 8'hAA, 8'hFF};
  localparam logic [7:0] T_PIN [NV] = '{8'hFE, 8'h00, 8'h00, 8'h5A, 8'h0F, 8'hFF};
  localparam logic [7:0] T_REQ [NV] = '{8'h01, 8'hFF, 8'h0F, 8'hA0, 8'hA0, 8'h00};

  function automatic logic [31:0] lword(logic [7:0] v);
    logic [31:0] w = '0;
    for (int n = 0; n < 8; n++) w[31-n] = v[n];
    return w;
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 req", {24'b0, req}, 32'h0);
    check("R1 mchk", {31'b0, mchk}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rd(2'd0, r); check("R1 sense", r, 32'h0);
    rd(2'd1, r); check("R1 pend", r, 32'h0);
    rd(2'd2, r); check("R1 mask", r, 32'h0);

    // R4 / R5: table of level-mode patterns
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, lword(T_EN[i]));
      irq_n = T_PIN[i];
      settle();
      check("R5 table req", {24'b0, req}, {24'b0, T_REQ[i]});
      rd(2'd1, r);
      check("R4 table pend", r, lword(~T_PIN[i]));
    end

    // R2: unused address reads zero
    rd(2'd3, r); check("R2 addr3", r, 32'h0);

    // R3: reserved sense bits ignored
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); check("R3 sense readback", r, 32'h0000_FF00);

    // R4: level line ignores write-one clear
    wr(2'd0, 32'h0);
    irq_n = 8'hFB;
    settle();
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); check("R4 level w1c ignored", r, lword(8'h04));
    irq_n = 8'hFF;
    settle();

    // R6: edge on line 3 latched after pin returns high
    wr(2'd2, lword(8'hFF));
    wr(2'd0, 32'h0000_FF00);
    irq_n = 8'hF7; settle();
    irq_n = 8'hFF; settle();
    rd(2'd1, r); check("R6 edge latched", r, lword(8'h08));
    check("R6 edge req", {24'b0, req}, 32'h08);

    // R7: write zero keeps, write one clears
    wr(2'd1, 32'h0);
    rd(2'd1, r); check("R7 write0 keeps", r, lword(8'h08));
    wr(2'd1, lword(8'h08));
    settle();
    rd(2'd1, r); check("R7 write1 clears", r, 32'h0);
    check("R7 req cleared", {24'b0, req}, 32'h0);

    // R3: line 7 edge select sits at bit 8
    wr(2'd0, 32'h0000_0100);
    irq_n = 8'h7F; settle();
    irq_n = 8'hFF; settle();
    rd(2'd1, r); check("R3 line7 edge bit8", r, lword(8'h80));
    wr(2'd1, lword(8'h80));

    // R3: line 0 edge select sits at bit 15
    wr(2'd0, 32'h0000_8000);
    irq_n = 8'hFE; settle();
    irq_n = 8'hFF; settle();
    rd(2'd1, r); check("R3 line0 edge bit15", r, lword(8'h01));
    wr(2'd1, lword(8'h01));

    // R8: clear write lands on the cycle the falling edge is detected
    wr(2'd0, 32'h0000_FF00);
    @(negedge clk);
    irq_n = 8'hDF;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = lword(8'h20);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    rd(2'd1, r); check("R8 event wins", r, lword(8'h20));
    irq_n = 8'hFF; settle();
    wr(2'd1, lword(8'h20));

    // R9: routing of line 0
    wr(2'd0, 32'h0);
    wr(2'd2, lword(8'hFF) | 32'h1);
    rd(2'd2, r); check("R9 mask readback", r, 32'hFF00_0001);
    irq_n = 8'hFE; settle();
    check("R9 mchk routed", {31'b0, mchk}, 32'h1);
    check("R9 req0 suppressed", {24'b0, req}, 32'h0);
    wr(2'd2, lword(8'hFF));
    settle();
    check("R9 mchk off", {31'b0, mchk}, 32'h0);
    check("R9 req0 normal", {24'b0, req}, 32'h01);
    irq_n = 8'hFF; settle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule